// File: doc/BRIEF.md
# Dual-Role SPI Byte Controller

This block is a byte-wide SPI port that works either as the clock-driving master or as a selected slave. Its role comes from a control word and from the level of the external slave-select pin. A flag in the same control word tells the block to ignore that pin. A master that sees its select pin pulled low by another device stops at once, gives up the master role and raises a fault flag.

Software-side access is a control-word write port and a single data register. A write to the data register in master mode loads the byte to send and starts an exchange of eight bits. When the exchange ends, the same register holds the byte that came in and a completion flag is raised.

Both bit orders and all four clock polarity and phase combinations are supported. In master mode a two-bit rate field selects one of four SCLK rates derived from the system clock. In slave mode the block samples the external SCLK and select pin through two-stage synchronisers, so a remote master must keep each SCLK half period well above three system clocks.

Top module: `spi_dual_role`

## Requirements
- R1: The control word holds: bit 0 LSB-first, bit 1 master request, bit 2 CPOL, bit 3 CPHA, bits 5:4 rate, bit 6 ignore-select. With ignore-select 1 the role is master exactly when the master request is 1. With ignore-select 0 the role is master only when the master request is 1 and the select pin (active low) is high. A low select pin makes the block a slave.
- R2: If the master request is 1, ignore-select is 0 and the synchronised select pin is low, the block clears the master request, sets `mode_fault` and aborts any transfer without raising `xfer_done`. The next control-word write clears `mode_fault`.
- R3: In master mode, a data write while idle starts a transfer of exactly 16 SCLK edges. After the last edge `xfer_done` is 1 and the data register reads back the received byte. `xfer_done` stays set until the next data write, which clears it.
- R4: The rate values 0, 1, 2 and 3 give an SCLK half period of 2, 8, 32 and 64 system clocks. `xfer_done` first reads 1 exactly 16 half periods plus one clock after the write edge.
- R5: LSB-first 0 shifts bit 7 first and LSB-first 1 shifts bit 0 first. The order applies to both the sent and the received byte.
- R6: SCLK rests at CPOL when idle, and the first edge of each bit (the leading edge) moves it away from CPOL. SCLK is back at CPOL when a transfer ends or aborts.
- R7: With CPHA 0 the first bit is on the data line before the first edge. This includes slave MISO as soon as the select pin goes low. Bits are sampled on leading edges and changed on trailing edges.
- R8: With CPHA 1 each bit is driven on a leading edge and sampled on the following trailing edge.
- R9: In slave mode, MISO output enable is high only while the select pin is low. The slave sends the data register and receives one byte per select period. After the eighth sampled bit it sets `xfer_done` and the data register holds the received byte.
- R10: A data write while a master transfer is running is ignored. The transfer completes with the received byte.
- R11: After reset the block is a slave with all control bits 0, `xfer_done` and `mode_fault` 0, the data register 0 and SCLK, MOSI and MISO output enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_wdata | input | 7 | Control word (layout in R1) |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rdata | output | 8 | Data register contents |
| xfer_done | output | 1 | Transfer complete flag |
| mode_fault | output | 1 | Master lost to a low select pin |
| is_master | output | 1 | Resolved role, 1 = master |
| sclk_i | input | 1 | SCLK from the bus (slave) |
| sclk_o | output | 1 | SCLK to the bus (master) |
| sclk_oe | output | 1 | SCLK output enable |
| mosi_i | input | 1 | MOSI from the bus (slave) |
| mosi_o | output | 1 | MOSI to the bus (master) |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO from the bus (master) |
| miso_o | output | 1 | MISO to the bus (slave) |
| miso_oe | output | 1 | MISO output enable |
| ss_n_i | input | 1 | Slave-select pin, active low |

## Verification
The hardest case to reach is a mode fault in the middle of a running master exchange. The bench starts a slow-rate transfer with ignore-select 0, pulls the select pin low after a few SCLK edges, and then checks that the role, the fault flag, the completion flag and the data register all behave as R2 requires. The other hard case is the slave's first CPHA 0 bit, which must be on MISO before any clock edge arrives. The bench reads MISO one clock after lowering the select pin, before it produces any SCLK. The master path is swept over every polarity, phase, order and rate. Bit positions and transfer lengths are predicted arithmetically.

// File: rtl/spi_pkg.sv
// Package: shared control-word layout for the dual-role SPI controller.
// Assumes the control word is written as a whole; no field is written alone.
package spi_pkg;

    localparam int CFG_W = 7;

    // Control word, MSB first: ignore-select, rate, phase, polarity, master, order
    typedef struct packed {
        logic       ss_ignore;
        logic [1:0] rate;
        logic       cpha;
        logic       cpol;
        logic       master_req;
        logic       lsb_first;
    } spi_cfg_t;

endpackage

// File: rtl/spi_sync.sv
// spi_sync: multi-stage synchroniser for a small bus of asynchronous pins.
// Assumes each bit is an independent level; no bus coherency is implied.
module spi_sync #(
    parameter int         W       = 2,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the pin levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_divider.sv
// spi_divider: produces one tick per SCLK half period while run is high.
// Assumes every half-period value is at least 2 and HALF3 is the largest.
module spi_divider #(
    parameter int HALF0 = 2,
    parameter int HALF1 = 8,
    parameter int HALF2 = 32,
    parameter int HALF3 = 64,
    localparam int CNT_W = $clog2(HALF3)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    // Pick the reload value for the selected rate.
    always_comb begin
        case (rate)
            2'd0:    reload = CNT_W'(HALF0 - 1);
            2'd1:    reload = CNT_W'(HALF1 - 1);
            2'd2:    reload = CNT_W'(HALF2 - 1);
            default: reload = CNT_W'(HALF3 - 1);
        endcase
    end

    // Hold at reload while idle, count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (!run || cnt_q == '0)    cnt_q <= reload;
        else                             cnt_q <= cnt_q - CNT_W'(1);
    end

    assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/spi_shifter.sv
// spi_shifter: transmit and receive shift registers shared by both roles.
// Assumes load, shift and sample are single-cycle strobes; load wins over shift.
module spi_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lsb_first,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          shift,
    input  logic          sample,
    input  logic          sample_bit,
    output logic          tx_bit,
    output logic [DW-1:0] rx_nxt
);
    logic [DW-1:0] tx_q;
    logic [DW-1:0] rx_q;

    // Next receive value including a bit sampled this cycle.
    always_comb begin
        if (!sample)        rx_nxt = rx_q;
        else if (lsb_first) rx_nxt = {sample_bit, rx_q[DW-1:1]};
        else                rx_nxt = {rx_q[DW-2:0], sample_bit};
    end

    // Load or advance the transmit register.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_q <= '0;
        else if (load)      tx_q <= load_val;
        else if (shift)     tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
    end

    // Collect sampled bits.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_nxt;
    end

    assign tx_bit = lsb_first ? tx_q[0] : tx_q[DW-1];
endmodule

// File: rtl/spi_dual_role.sv
// spi_dual_role: byte SPI port acting as master or slave.
// Resolves the role from the control word and the select pin, runs master
// transfers from an internal divider, and follows an external clock as slave.
// Assumes a remote master's SCLK half period exceeds three system clocks.
module spi_dual_role
    import spi_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HALF0       = 2,
    parameter int HALF1       = 8,
    parameter int HALF2       = 32,
    parameter int HALF3       = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CFG_W-1:0] ctl_wdata,
    input  logic             dat_wr,
    input  logic [DW-1:0]    dat_wdata,
    output logic [DW-1:0]    dat_rdata,
    output logic             xfer_done,
    output logic             mode_fault,
    output logic             is_master,
    input  logic             sclk_i,
    output logic             sclk_o,
    output logic             sclk_oe,
    input  logic             mosi_i,
    output logic             mosi_o,
    output logic             mosi_oe,
    input  logic             miso_i,
    output logic             miso_o,
    output logic             miso_oe,
    input  logic             ss_n_i
);
    localparam int EDGES = 2 * DW;
    localparam int EW    = $clog2(EDGES);
    localparam int SCW   = $clog2(DW + 1);

    spi_cfg_t      cfg_q;
    logic          fault_q;
    logic          ss_s, sclk_s, sclk_p;
    logic          master_w, fault_hit;
    logic [DW-1:0] data_q;
    logic          done_q;

    // master sequencer state
    logic          m_busy;
    logic [EW-1:0] m_idx;
    logic          sclk_q;
    logic          tick;
    logic          m_start, m_edge, m_lead, m_last;
    logic          m_sample, m_shift, m_finish, m_abort;

    // slave tracking state
    logic [SCW-1:0] s_cnt;
    logic           s_seen;
    logic           s_sel, s_edge, s_lead, s_sample, s_shift, s_finish;

    // shared shifter controls
    logic          sh_load, sh_shift, sh_sample, sh_bit, tx_bit;
    logic [DW-1:0] sh_val, rx_nxt;

    spi_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, sclk_i}),
        .q     ({ss_s, sclk_s})
    );

    // Role resolution and fault detection from the synchronised select pin.
    assign master_w  = cfg_q.master_req && (cfg_q.ss_ignore || ss_s);
    assign fault_hit = cfg_q.master_req && !cfg_q.ss_ignore && !ss_s;

    // Control word and fault flag; a fault drops the master request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            fault_q <= 1'b0;
        end else if (ctl_wr) begin
            cfg_q   <= spi_cfg_t'(ctl_wdata);
            fault_q <= 1'b0;
        end else if (fault_hit) begin
            cfg_q.master_req <= 1'b0;
            fault_q          <= 1'b1;
        end
    end

    spi_divider #(
        .HALF0 (HALF0),
        .HALF1 (HALF1),
        .HALF2 (HALF2),
        .HALF3 (HALF3)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (m_busy),
        .rate  (cfg_q.rate),
        .tick  (tick)
    );

    // Master edge decode: even edge index is leading, odd is trailing.
    assign m_start  = dat_wr && master_w && !m_busy;
    assign m_abort  = m_busy && !master_w;
    assign m_edge   = m_busy && master_w && tick;
    assign m_lead   = !m_idx[0];
    assign m_last   = (m_idx == EW'(EDGES - 1));
    assign m_sample = m_edge && (cfg_q.cpha ? !m_lead : m_lead);
    assign m_shift  = m_edge && (cfg_q.cpha ? (m_lead && m_idx != '0)
                                            : (!m_lead && !m_last));
    assign m_finish = m_edge && m_last;

    // Master sequencer: start, edge counting, abort and SCLK level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0;
            m_idx  <= '0;
            sclk_q <= 1'b0;
        end else if (m_abort) begin
            m_busy <= 1'b0;
            m_idx  <= '0;
            sclk_q <= cfg_q.cpol;
        end else if (m_start) begin
            m_busy <= 1'b1;
            m_idx  <= '0;
            sclk_q <= cfg_q.cpol;
        end else if (m_edge) begin
            sclk_q <= !sclk_q;
            m_idx  <= m_idx + EW'(1);
            if (m_last) m_busy <= 1'b0;
        end else if (!m_busy) begin
            sclk_q <= cfg_q.cpol;
        end
    end

    // Remember the previous synchronised SCLK for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_p <= 1'b0;
        else        sclk_p <= sclk_s;
    end

    // Slave edge decode: leading edges move SCLK away from CPOL.
    assign s_sel    = !master_w && !ss_s;
    assign s_edge   = s_sel && (sclk_s != sclk_p) && (s_cnt < SCW'(DW));
    assign s_lead   = (sclk_s != cfg_q.cpol);
    assign s_sample = s_edge && (cfg_q.cpha ? !s_lead : s_lead);
    assign s_shift  = s_edge && (cfg_q.cpha ? (s_lead && s_seen) : !s_lead);
    assign s_finish = s_sample && (s_cnt == SCW'(DW - 1));

    // Slave bit count and first-leading-edge tracking per select period.
    always_ff @(posedge clk) begin
        if (!rst_n || !s_sel) begin
            s_cnt  <= '0;
            s_seen <= 1'b0;
        end else if (s_edge) begin
            if (s_sample) s_cnt  <= s_cnt + SCW'(1);
            if (s_lead)   s_seen <= 1'b1;
        end
    end

    // Shared shifter: master drives MOSI from it, slave drives MISO from it.
    assign sh_load   = m_start || (!master_w && ss_s);
    assign sh_val    = m_start ? dat_wdata : data_q;
    assign sh_shift  = m_shift || s_shift;
    assign sh_sample = m_sample || s_sample;
    assign sh_bit    = master_w ? miso_i : mosi_i;

    spi_shifter #(
        .DW (DW)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .lsb_first  (cfg_q.lsb_first),
        .load       (sh_load),
        .load_val   (sh_val),
        .shift      (sh_shift),
        .sample     (sh_sample),
        .sample_bit (sh_bit),
        .tx_bit     (tx_bit),
        .rx_nxt     (rx_nxt)
    );

    // Data register and completion flag; completion wins over a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            done_q <= 1'b0;
        end else if (m_finish || s_finish) begin
            data_q <= rx_nxt;
            done_q <= 1'b1;
        end else if (dat_wr && !(master_w && m_busy)) begin
            data_q <= dat_wdata;
            done_q <= 1'b0;
        end
    end

    assign dat_rdata  = data_q;
    assign xfer_done  = done_q;
    assign mode_fault = fault_q;
    assign is_master  = master_w;
    assign sclk_o     = sclk_q;
    assign sclk_oe    = master_w;
    assign mosi_o     = tx_bit;
    assign mosi_oe    = master_w;
    assign miso_o     = tx_bit;
    assign miso_oe    = !master_w && !ss_n_i;
endmodule

// File: rtl/spi_dual_role_chk.sv
// spi_dual_role_chk: property checker bound to spi_dual_role.
// Assumes the default two-stage select synchroniser.
module spi_dual_role_chk (
    input logic clk,
    input logic rst_n,
    input logic ss_n_i,
    input logic miso_oe,
    input logic is_master,
    input logic mode_fault,
    input logic sclk_o,
    input logic busy,
    input logic cpol,
    input logic ign,
    input logic done,
    input logic dat_wr
);
    // R1: a select pin held low with ignore-select 0 forbids the master role
    p_ss_low_slave_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ign && !$past(ss_n_i, 2) && !$past(ss_n_i, 1)) |-> !is_master);

    // R2: a raised fault flag always coincides with the slave role
    p_fault_slave_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_fault |-> !is_master);

    // R3: completion flag holds until a data write
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dat_wr) |=> done);

    // R6: SCLK is at its idle level when a transfer ends
    p_sclk_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $stable(cpol)) |-> (sclk_o == cpol));

    // R9: MISO never driven while the select pin is high
    p_miso_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_i |-> !miso_oe);
endmodule

bind spi_dual_role spi_dual_role_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_n_i     (ss_n_i),
    .miso_oe    (miso_oe),
    .is_master  (is_master),
    .mode_fault (mode_fault),
    .sclk_o     (sclk_o),
    .busy       (m_busy),
    .cpol       (cfg_q.cpol),
    .ign        (cfg_q.ss_ignore),
    .done       (xfer_done),
    .dat_wr     (dat_wr)
);

// File: tb/tb_spi_dual_role.sv
// tb_spi_dual_role: sweeps role table, all master modes and rates, all slave
// modes, and a mid-transfer mode fault; expectations computed in the bench.
module tb_spi_dual_role;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [6:0] ctl_wdata = '0;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       xfer_done, mode_fault, is_master;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n = 1'b1;
    logic       sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_dual_role dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .xfer_done(xfer_done), .mode_fault(mode_fault), .is_master(is_master),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit bitof(input logic [7:0] v, input int i, input bit lsb);
        return lsb ? v[i] : v[7-i];
    endfunction

    task automatic write_ctl(input bit ign, input bit [1:0] rate, input bit cpha,
                             input bit cpol, input bit mstr, input bit lsb);
        @(negedge clk);
        ctl_wr    = 1'b1;
        ctl_wdata = {ign, rate, cpha, cpol, mstr, lsb};
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    // Master transfer with the bench acting as slave.
    task automatic run_master(input bit cpol, input bit cpha, input bit lsb,
                              input bit [1:0] rate, input bit ign,
                              input logic [7:0] tx, input logic [7:0] sl);
        int half, n, edges, s, j;
        logic prev;
        logic [7:0] got;
        ss_n = 1'b1;
        wait_n(4);
        write_ctl(ign, rate, cpha, cpol, 1'b1, lsb);
        wait_n(4);
        if (ign) ss_n = 1'b0;
        wait_n(4);
        chk(is_master == 1'b1, "R1 master role", int'(is_master), 1);
        chk(sclk_o == cpol, "R6 idle level", int'(sclk_o), int'(cpol));
        half = (rate == 2'd0) ? 2 : (rate == 2'd1) ? 8 : (rate == 2'd2) ? 32 : 64;
        j = 0;
        if (!cpha) begin
            miso_i = bitof(sl, 0, lsb);
            j = 1;
        end
        @(negedge clk);
        dat_wr = 1'b1;
        dat_wdata = tx;
        prev = cpol; n = 0; edges = 0; s = 0; got = '0;
        do begin
            @(negedge clk);
            n++;
            dat_wr    = (n == 3);     // R10 collision write
            dat_wdata = ~tx;
            if (sclk_o !== prev) begin
                edges++;
                prev = sclk_o;
                if ((sclk_o != cpol) ^ cpha) begin
                    if (s < 8) begin
                        if (lsb) got[s] = mosi_o; else got[7-s] = mosi_o;
                    end
                    s++;
                end else begin
                    if (j < 8) miso_i = bitof(sl, j, lsb);
                    j++;
                end
            end
        end while (!xfer_done && n < 3000);
        dat_wr = 1'b0;
        chk(n == 16 * half + 1, "R4 transfer length", n, 16 * half + 1);
        chk(edges == 16, "R3 edge count", edges, 16);
        chk(got == tx, cpha ? "R8 R5 sent byte" : "R7 R5 sent byte", int'(got), int'(tx));
        chk(dat_rdata == sl, "R3 R10 received byte", int'(dat_rdata), int'(sl));
        chk(sclk_o == cpol, "R6 end level", int'(sclk_o), int'(cpol));
    endtask

    // Slave transfer with the bench acting as master (half period 8 clocks).
    task automatic run_slave(input bit cpol, input bit cpha, input bit lsb,
                             input logic [7:0] tx, input logic [7:0] mo);
        logic [7:0] got;
        ss_n = 1'b1;
        sclk_i = cpol;
        wait_n(2);
        write_ctl(1'b0, 2'd0, cpha, cpol, 1'b0, lsb);
        @(negedge clk);
        dat_wr = 1'b1;
        dat_wdata = tx;
        @(negedge clk);
        dat_wr = 1'b0;
        wait_n(4);
        chk(xfer_done == 1'b0, "R3 write clears done", int'(xfer_done), 0);
        chk(miso_oe == 1'b0, "R9 MISO off when deselected", int'(miso_oe), 0);
        ss_n = 1'b0;
        @(negedge clk);
        chk(miso_oe == 1'b1, "R9 MISO on when selected", int'(miso_oe), 1);
        if (!cpha)
            chk(miso_o == bitof(tx, 0, lsb), "R7 first bit before clock",
                int'(miso_o), int'(bitof(tx, 0, lsb)));
        wait_n(4);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            if (!cpha) begin
                mosi_i = bitof(mo, i, lsb);
                wait_n(8);
                sclk_i = ~cpol;
                if (lsb) got[i] = miso_o; else got[7-i] = miso_o;
                wait_n(8);
                sclk_i = cpol;
            end else begin
                wait_n(8);
                sclk_i = ~cpol;
                mosi_i = bitof(mo, i, lsb);
                wait_n(8);
                if (lsb) got[i] = miso_o; else got[7-i] = miso_o;
                sclk_i = cpol;
            end
        end
        wait_n(8);
        chk(xfer_done == 1'b1, "R9 slave done", int'(xfer_done), 1);
        chk(dat_rdata == mo, "R9 R5 slave received", int'(dat_rdata), int'(mo));
        chk(got == tx, cpha ? "R8 slave sent" : "R7 slave sent", int'(got), int'(tx));
        ss_n = 1'b1;
        wait_n(2);
        chk(miso_oe == 1'b0, "R9 MISO released", int'(miso_oe), 0);
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        // R11 reset state
        chk(is_master == 1'b0, "R11 role", int'(is_master), 0);
        chk(xfer_done == 1'b0, "R11 done", int'(xfer_done), 0);
        chk(mode_fault == 1'b0, "R11 fault", int'(mode_fault), 0);
        chk(dat_rdata == 8'h00, "R11 data", int'(dat_rdata), 0);
        chk({sclk_oe, mosi_oe, miso_oe} == 3'b000, "R11 enables",
            int'({sclk_oe, mosi_oe, miso_oe}), 0);

        // R1 / R2 role table
        for (int c = 0; c < 8; c++) begin
            bit ign, mstr, ssh, em, ef;
            ign = c[2]; mstr = c[1]; ssh = c[0];
            ss_n = 1'b1;
            write_ctl(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
            ss_n = ssh;
            wait_n(4);
            write_ctl(ign, 2'd0, 1'b1, 1'b0, mstr, 1'b0);
            wait_n(5);
            em = mstr && (ign || ssh);
            ef = mstr && !ign && !ssh;
            chk(is_master == em, "R1 role table", int'(is_master), int'(em));
            chk(mode_fault == ef, "R2 fault table", int'(mode_fault), int'(ef));
        end
        write_ctl(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(mode_fault == 1'b0, "R2 fault cleared by control write", int'(mode_fault), 0);

        // R3..R8, R10 master sweep
        for (int k = 0; k < 32; k++) begin
            logic [7:0] tx, sl;
            tx = 8'(k * 37 + 5);
            sl = 8'(k * 91 + 8'h5a);
            run_master(k[0], k[1], k[2], k[4:3], k[0], tx, sl);
        end

        // R9 slave sweep
        for (int k = 0; k < 8; k++) begin
            logic [7:0] tx, mo;
            tx = 8'(k * 53 + 8'h1c);
            mo = 8'(k * 29 + 8'hc3);
            run_slave(k[0], k[1], k[2], tx, mo);
        end

        // R2 abort in mid-transfer
        ss_n = 1'b1;
        wait_n(4);
        write_ctl(1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        wait_n(4);
        @(negedge clk);
        dat_wr = 1'b1;
        dat_wdata = 8'hA5;
        @(negedge clk);
        dat_wr = 1'b0;
        wait_n(30);
        ss_n = 1'b0;
        wait_n(5);
        chk(is_master == 1'b0, "R2 abort drops role", int'(is_master), 0);
        chk(mode_fault == 1'b1, "R2 abort sets fault", int'(mode_fault), 1);
        chk(sclk_o == 1'b1, "R6 abort idle level", int'(sclk_o), 1);
        wait_n(200);
        chk(xfer_done == 1'b0, "R2 abort no done", int'(xfer_done), 0);
        chk(dat_rdata == 8'hA5, "R2 abort data kept", int'(dat_rdata), 8'hA5);
        ss_n = 1'b1;
        wait_n(5);
        chk(is_master == 1'b0, "R2 master request cleared", int'(is_master), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule